// File: doc/BRIEF.md
# Zero-Page Microcoded Instruction Sequencer

This block is a small execution unit for an 8-bit processor. It steps through a fixed sequence of bus cycles for each supported zero-page instruction. The sequence reads the opcode, then the operand byte, then the zero-page location. Read-modify-write instructions then compute a result, write it back, and end by fetching the next opcode. The block holds the accumulator, the two index registers, the program counter and the N, Z and C flags. It also holds internal state: an operand latch B, a result register T, a pointer byte, and the instruction register.

The block talks to a single-port byte memory. It drives the address, the write data and a write enable, and it takes the read data back combinationally in the same cycle. The load family and the shift-then-OR instruction come from a deliberate don't-care decode of the two low opcode bits. One rule on opcode bit 0 decides whether latch B follows the data bus on a write cycle. Any other opcode is caught at decode and parks the block until reset. The registers and flags are brought out on ports so that an enclosing core or a bench can observe them.

Top module: `zp_seq_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, memAddr equals resetVector, opFetch is 1, memWe is 0, illegalOp is 0, and accA, idxX, idxY, flagN, flagZ and flagC are all 0.
- R2: Opcodes 0xA4 to 0xA7 load the addressed zero-page byte. The load target comes from opcode bits [1:0]: 00 loads idxY, 01 loads accA, 10 loads idxX, and 11 loads both accA and idxX. Registers that are not targets keep their values.
- R3: A load takes 3 cycles. It sets flagN to bit 7 of the loaded byte and sets flagZ when that byte is zero. flagC is unchanged and no write occurs.
- R4: Opcode 0x05 sets accA to accA OR M, where M is the zero-page byte. It updates flagN and flagZ from the new accA, leaves flagC unchanged, takes 3 cycles and makes no write.
- R5: Opcode 0x06 writes M shifted left by one (0 into bit 0) back to the same location. It sets flagC to M bit 7 and sets flagN and flagZ from the shifted byte. accA is unchanged. It takes 5 cycles.
- R6: Opcode 0x07 writes and sets flagC exactly as R5 does. It then sets accA to accA OR (M shifted left), and sets flagN and flagZ from the new accA. It takes 5 cycles.
- R7: Opcode 0x04 writes accA OR M. It sets flagZ when accA AND M is zero, using the value of M from before the write. accA, flagN and flagC are unchanged. It takes 5 cycles.
- R8: Opcode 0x14 writes (NOT accA) AND M. Its flags, registers and cycle count are as in R7.
- R9: Each write goes to address {0x00, operand byte}. A read-modify-write instruction makes exactly one single-cycle write. Every other instruction makes none.
- R10: Opcode and operand bytes are read from consecutive addresses starting at resetVector. opFetch is 1 exactly in the cycles that read an opcode.
- R11: Any opcode outside the nine listed sets illegalOp two cycles after the cycle that reads that opcode. From then until reset, illegalOp stays 1, memWe stays 0, and memAddr holds the address just past that opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| resetVector | input | 16 | Program counter value loaded in reset |
| memAddr | output | 16 | Memory address for this cycle |
| memRdata | input | 8 | Read data, valid in the same cycle |
| memWdata | output | 8 | Write data |
| memWe | output | 1 | Write enable for this cycle |
| opFetch | output | 1 | This cycle reads an opcode |
| illegalOp | output | 1 | Unsupported opcode seen; block halted |
| accA | output | 8 | Accumulator |
| idxX | output | 8 | X index register |
| idxY | output | 8 | Y index register |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |

## Verification
A wrong step count shows at the ports as a next opcode fetch that arrives early or late. Because every program ends in an illegal opcode, that error shifts the rising edge of illegalOp and is measured to the cycle. A B latch that is relatched on a write it should skip, or skipped on a write it should follow, corrupts nothing on the bus. It shows one cycle later as a wrong flagZ after 0x04 or 0x14, or as a wrong accA after 0x07. A wrong load-target decode shows at once in the register ports after the load's final cycle. Sweeping opcode, accumulator and memory value over edge patterns brings each of these out.

// File: rtl/zp_seq_pkg.sv
package zp_seq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int STEP_W = 3;

  localparam logic [DW-1:0] OP_TSB = 8'h04;
  localparam logic [DW-1:0] OP_ORA = 8'h05;
  localparam logic [DW-1:0] OP_ASL = 8'h06;
  localparam logic [DW-1:0] OP_SLO = 8'h07;
  localparam logic [DW-1:0] OP_TRB = 8'h14;
  localparam logic [DW-3:0] OP_LOAD_HI = 6'b101001;

  typedef enum logic [1:0] {NZ_MEM, NZ_SHIFT, NZ_OR} nzSel_e;
  typedef enum logic [1:0] {T_SHL, T_SET, T_CLR} tOp_e;

  typedef struct packed {
    logic   addrZp;
    logic   memWe;
    logic   loadIr;
    logic   incPc;
    logic   loadDpl;
    logic   loadB;
    logic   loadReg;
    logic   loadT;
    tOp_e   tOp;
    logic   setNz;
    nzSel_e nzSel;
    logic   setC;
    logic   setZAnd;
    logic   orToA;
  } ctl_t;
endpackage

// File: rtl/zp_seq_ctrl.sv
module zp_seq_ctrl
  import zp_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] ir,
  output ctl_t          ctl,
  output logic          halted
);
  logic [STEP_W-1:0] step, stepNext;
  logic haltNext;
  logic isLoad, isOra, isShift, isBitOp, legal;

  assign isLoad  = (ir[DW-1:2] == OP_LOAD_HI);
  assign isOra   = (ir == OP_ORA);
  assign isShift = (ir == OP_ASL) || (ir == OP_SLO);
  assign isBitOp = (ir == OP_TSB) || (ir == OP_TRB);
  assign legal   = isLoad || isOra || isShift || isBitOp;

  always_comb begin
    ctl      = '0;
    stepNext = step;
    haltNext = halted;
    if (!halted) begin
      case (step)
        3'd0: begin
          ctl.loadIr = 1'b1; ctl.incPc = 1'b1; stepNext = 3'd1;
        end
        3'd1: begin
          if (!legal) haltNext = 1'b1;
          else begin
            ctl.loadDpl = 1'b1; ctl.incPc = 1'b1; stepNext = 3'd2;
          end
        end
        3'd2: begin
          ctl.addrZp = 1'b1;
          if (isLoad) begin
            ctl.loadReg = 1'b1; ctl.setNz = 1'b1; ctl.nzSel = NZ_MEM;
          end else begin
            ctl.loadB = 1'b1;
          end
          stepNext = 3'd3;
        end
        3'd3: begin
          if (isLoad || isOra) begin
            if (isOra) begin
              ctl.orToA = 1'b1; ctl.setNz = 1'b1; ctl.nzSel = NZ_OR;
            end
            ctl.loadIr = 1'b1; ctl.incPc = 1'b1; stepNext = 3'd1;
          end else if (isShift) begin
            ctl.loadT = 1'b1; ctl.tOp = T_SHL;
            ctl.setNz = 1'b1; ctl.nzSel = NZ_SHIFT; ctl.setC = 1'b1;
            stepNext = 3'd4;
          end else begin
            ctl.addrZp = 1'b1; ctl.loadB = 1'b1; ctl.loadT = 1'b1;
            ctl.tOp = ir[4] ? T_CLR : T_SET;
            stepNext = 3'd4;
          end
        end
        3'd4: begin
          ctl.addrZp = 1'b1; ctl.memWe = 1'b1; stepNext = 3'd5;
        end
        3'd5: begin
          if (isBitOp) ctl.setZAnd = 1'b1;
          else if (ir[0]) begin
            ctl.orToA = 1'b1; ctl.setNz = 1'b1; ctl.nzSel = NZ_OR;
          end
          ctl.loadIr = 1'b1; ctl.incPc = 1'b1; stepNext = 3'd1;
        end
        default: stepNext = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step   <= '0;
      halted <= 1'b0;
    end else begin
      step   <= stepNext;
      halted <= haltNext;
    end
  end

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!ctl.memWe && !ctl.incPc && !ctl.loadIr));
  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWe |=> !ctl.memWe);
  assert_write_then_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWe |=> ctl.loadIr);
endmodule

// File: rtl/zp_seq_dpath.sv
module zp_seq_dpath
  import zp_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] resetVector,
  input  ctl_t          ctl,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] aReg,
  output logic [DW-1:0] xReg,
  output logic [DW-1:0] yReg,
  output logic          flagN,
  output logic          flagZ,
  output logic          flagC
);
  logic [AW-1:0] pc;
  logic [DW-1:0] dpl, bReg, tReg, tNext, aNext, nzVal, shifted;
  logic ldA, ldX, ldY, bCapture;

  assign shifted  = {bReg[DW-2:0], 1'b0};
  assign memAddr  = ctl.addrZp ? {{(AW-DW){1'b0}}, dpl} : pc;
  assign memWdata = tReg;

  // Don't-care decode of the two low opcode bits; 11 selects both A and X.
  assign ldY = ctl.loadReg & ~ir[1] & ~ir[0];
  assign ldA = (ctl.loadReg & ir[0]) | ctl.orToA;
  assign ldX = ctl.loadReg & ir[1];
  assign aNext = ctl.orToA ? (aReg | bReg) : memRdata;

  // Write cycles relatch B from the bus only for odd opcodes.
  assign bCapture = ctl.loadB | (ctl.memWe & ir[0]);

  always_comb begin
    case (ctl.tOp)
      T_SET:   tNext = aReg | bReg;
      T_CLR:   tNext = ~aReg & bReg;
      default: tNext = shifted;
    endcase
    case (ctl.nzSel)
      NZ_SHIFT: nzVal = shifted;
      NZ_OR:    nzVal = aReg | bReg;
      default:  nzVal = memRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= resetVector;
      ir <= '0; dpl <= '0; bReg <= '0; tReg <= '0;
      aReg <= '0; xReg <= '0; yReg <= '0;
      flagN <= 1'b0; flagZ <= 1'b0; flagC <= 1'b0;
    end else begin
      if (ctl.incPc)   pc   <= pc + 1'b1;
      if (ctl.loadIr)  ir   <= memRdata;
      if (ctl.loadDpl) dpl  <= memRdata;
      if (bCapture)    bReg <= ctl.memWe ? tReg : memRdata;
      if (ctl.loadT)   tReg <= tNext;
      if (ldA)         aReg <= aNext;
      if (ldX)         xReg <= memRdata;
      if (ldY)         yReg <= memRdata;
      if (ctl.setNz) begin
        flagN <= nzVal[DW-1];
        flagZ <= (nzVal == '0);
      end
      if (ctl.setZAnd) flagZ <= ((aReg & bReg) == '0);
      if (ctl.setC)    flagC <= bReg[DW-1];
    end
  end

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incPc |=> (pc == $past(pc) + 1'b1));
  assert_b_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWe && !ir[0]) |=> (bReg == $past(bReg)));
  assert_b_relatch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWe && ir[0]) |=> (bReg == $past(memWdata)));
  assert_zp_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWe |-> (memAddr[AW-1:DW] == '0));
endmodule

// File: rtl/zp_seq_core.sv
module zp_seq_core
  import zp_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] resetVector,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic          opFetch,
  output logic          illegalOp,
  output logic [DW-1:0] accA,
  output logic [DW-1:0] idxX,
  output logic [DW-1:0] idxY,
  output logic          flagN,
  output logic          flagZ,
  output logic          flagC
);
  ctl_t ctl;
  logic [DW-1:0] ir;
  logic halted;

  zp_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ir(ir), .ctl(ctl), .halted(halted)
  );

  zp_seq_dpath i_dpath (
    .clk(clk), .rstN(rstN), .resetVector(resetVector), .ctl(ctl),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .ir(ir),
    .aReg(accA), .xReg(idxX), .yReg(idxY),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );

  assign memWe     = ctl.memWe;
  assign opFetch   = ctl.loadIr;
  assign illegalOp = halted;
endmodule

// File: tb/test_zp_seq_core.sv
module test_zp_seq_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] resetVector = 16'h0200;
  logic [15:0] memAddr;
  logic [7:0] memRdata, memWdata, accA, idxX, idxY;
  logic memWe, opFetch, illegalOp, flagN, flagZ, flagC;
  logic [7:0] mem [0:1023];
  int nTests = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  zp_seq_core i_zp_seq_core (
    .clk(clk), .rstN(rstN), .resetVector(resetVector), .memAddr(memAddr),
    .memRdata(memRdata), .memWdata(memWdata), .memWe(memWe), .opFetch(opFetch),
    .illegalOp(illegalOp), .accA(accA), .idxX(idxX), .idxY(idxY),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );

  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWe) mem[memAddr[9:0]] <= memWdata;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  int cyc, nWr, nFetch;
  logic [15:0] wrAddr;
  logic [7:0] wrData;

  // Reset, release, and run until illegalOp rises; records cycles and writes.
  task automatic runProg(input logic [15:0] start);
    rstN = 1'b0;
    resetVector = start;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(memAddr == start && opFetch && !memWe && !illegalOp, "R1", "reset bus",
          memAddr, start);
    rstN = 1'b1;
    check(memAddr == start && opFetch && !memWe && !illegalOp, "R1", "first fetch",
          memAddr, start);
    check(accA == 0 && idxX == 0 && idxY == 0 && {flagN, flagZ, flagC} == 0, "R1",
          "reset regs", {accA, idxX, idxY}, 0);
    cyc = 0; nWr = 0; nFetch = 0;
    while (!illegalOp && cyc < 100) begin
      if (memWe) begin nWr++; wrAddr = memAddr; wrData = memWdata; end
      if (opFetch) nFetch++;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic checkHalt(input logic [15:0] expPc);
    bit quiet = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (memWe || !illegalOp || memAddr != expPc) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R11", "halt frozen", memAddr, expPc);
  endtask

  task automatic clearMem();
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
  endtask

  // Program: LDA $10 ; <op> $20 ; illegal 0x00
  task automatic runOp(input logic [7:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic [15:0] start);
    logic [7:0] eA, eX, eY, eMem, s;
    bit eN, eZ, eC, isRmw;
    int n;
    clearMem();
    mem[start[9:0]]     = 8'hA5; mem[start[9:0] + 1] = 8'h10;
    mem[start[9:0] + 2] = op;    mem[start[9:0] + 3] = 8'h20;
    mem[start[9:0] + 4] = 8'h00;
    mem[10'h010] = a; mem[10'h020] = m;
    eA = a; eX = 0; eY = 0; eMem = m; s = {m[6:0], 1'b0};
    eN = a[7]; eZ = (a == 0); eC = 0; isRmw = 0; n = 5;
    case (op)
      8'hA4, 8'hA5, 8'hA6, 8'hA7: begin
        n = 3;
        if (op[1:0] == 2'b00) eY = m;
        if (op[0]) eA = m;
        if (op[1]) eX = m;
        eN = m[7]; eZ = (m == 0);
      end
      8'h05: begin n = 3; eA = a | m; eN = eA[7]; eZ = (eA == 0); end
      8'h06: begin isRmw = 1; eMem = s; eC = m[7]; eN = s[7]; eZ = (s == 0); end
      8'h07: begin isRmw = 1; eMem = s; eC = m[7]; eA = a | s; eN = eA[7]; eZ = (eA == 0); end
      8'h04: begin isRmw = 1; eMem = a | m; eZ = ((a & m) == 0); end
      default: begin isRmw = 1; eMem = ~a & m; eZ = ((a & m) == 0); end
    endcase
    runProg(start);
    case (op)
      8'hA4, 8'hA5, 8'hA6, 8'hA7: begin
        check(accA == eA && idxX == eX && idxY == eY, "R2", "load targets",
              {accA, idxX, idxY}, {eA, eX, eY});
        check(flagN == eN && flagZ == eZ && flagC == eC && cyc == n + 5, "R3",
              "load flags/cycles", {flagN, flagZ, flagC, 8'(cyc)}, {eN, eZ, eC, 8'(n + 5)});
      end
      8'h05: check(accA == eA && {flagN, flagZ, flagC} == {eN, eZ, eC} && cyc == 8,
                   "R4", "ora", {accA, flagN, flagZ, flagC}, {eA, eN, eZ, eC});
      8'h06: check(accA == eA && mem[10'h020] == eMem && {flagN, flagZ, flagC} == {eN, eZ, eC}
                   && cyc == 10, "R5", "asl", {accA, mem[10'h020], flagN, flagZ, flagC},
                   {eA, eMem, eN, eZ, eC});
      8'h07: check(accA == eA && mem[10'h020] == eMem && {flagN, flagZ, flagC} == {eN, eZ, eC}
                   && cyc == 10, "R6", "slo", {accA, mem[10'h020], flagN, flagZ, flagC},
                   {eA, eMem, eN, eZ, eC});
      8'h04: check(accA == eA && mem[10'h020] == eMem && {flagN, flagZ, flagC} == {eN, eZ, eC}
                   && cyc == 10, "R7", "tsb", {accA, mem[10'h020], flagN, flagZ, flagC},
                   {eA, eMem, eN, eZ, eC});
      default: check(accA == eA && mem[10'h020] == eMem && {flagN, flagZ, flagC} == {eN, eZ, eC}
                   && cyc == 10, "R8", "trb", {accA, mem[10'h020], flagN, flagZ, flagC},
                   {eA, eMem, eN, eZ, eC});
    endcase
    if (isRmw)
      check(nWr == 1 && wrAddr == 16'h0020 && wrData == eMem, "R9", "one zp write",
            {8'(nWr), wrAddr}, {8'd1, 16'h0020});
    else
      check(nWr == 0, "R9", "no write", nWr, 0);
    check(nFetch == 3, "R10", "opcode fetch count", nFetch, 3);
    checkHalt(start + 16'd5);
  endtask

  localparam int NV = 6;
  logic [7:0] vals [0:NV-1] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
  logic [7:0] rmwOps [0:4] = '{8'h05, 8'h06, 8'h07, 8'h04, 8'h14};

  initial begin
    // R2/R3: load family sweep
    for (int o = 0; o < 4; o++)
      for (int v = 0; v < NV; v++)
        runOp(8'hA4 + 8'(o), 8'h3C, vals[v], 16'h0200);
    // R4..R9: ALU and read-modify-write sweep over accumulator x memory
    for (int o = 0; o < 5; o++)
      for (int ai = 0; ai < NV; ai++)
        for (int mi = 0; mi < NV; mi++)
          runOp(rmwOps[o], vals[ai], vals[mi], (o % 2) ? 16'h0300 : 16'h0200);
    // R11: unsupported opcodes as the very first instruction
    for (int k = 0; k < 4; k++) begin
      logic [7:0] bad;
      bad = (k == 0) ? 8'hEA : (k == 1) ? 8'hA8 : (k == 2) ? 8'h15 : 8'h00;
      clearMem();
      mem[10'h200] = bad;
      runProg(16'h0200);
      check(cyc == 2 && illegalOp && nWr == 0, "R11", "illegal detect", cyc, 2);
      checkHalt(16'h0201);
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule